// File: doc/BRIEF.md
# Operand-Stack Execution Core

This block is a small execution core with no register file. Every operand it works on sits in an internal last-in first-out operand stack of `DEPTH` words, `W` bits wide (16 x 32 by default). An instruction is a 3-bit opcode plus a data word, offered on a valid/ready handshake. A push opcode places the data word on top. A pop opcode removes the top word and presents it on an output port for one cycle. Arithmetic opcodes take no operand field. They read the two topmost entries and replace them with a single result. There are also opcodes that duplicate the top entry and exchange the top two.

A two-state controller sequences each instruction. In state `ST_IDLE`, `ready` is high and the core waits. The transition `accept` (instr_valid while ready) latches the opcode and data and moves to `ST_EXEC`. In `ST_EXEC`, `ready` is low and the stack update is committed at the next clock edge. The transition `retire` then returns the controller to `ST_IDLE` unconditionally. Each instruction therefore occupies exactly one busy cycle after it is accepted.

Instructions that would take the stack past either end are refused and leave the stack untouched. Each refusal sets one of two sticky error flags, which are cleared only by reset. The top entry, the current depth, and empty/full indications are visible at all times.

Top module: `stk_core`

## Requirements
- R1: After reset, ready is 1, depth is 0, empty is 1, full is 0, tos is 0, and err_over, err_under and pop_valid are 0.
- R2: An instruction is accepted on a clock edge where instr_valid and ready are both 1. Ready is then 0 for exactly one cycle. When ready returns to 1, the stack outputs already show the result. Depth never changes on an edge that ends a cycle in which ready was 1.
- R3: Opcode 1 (push) on a stack that is not full places instr_data on top and raises depth by one.
- R4: Opcode 2 (pop) on a non-empty stack lowers depth by one. It also drives the removed top word on pop_data with pop_valid high for exactly one cycle, the cycle in which ready returns to 1.
- R5: Opcode 3 (add) and opcode 5 (multiply) with at least two entries replace the two top entries with, respectively, their sum modulo 2^W and the low W bits of their product. Depth drops by one.
- R6: Opcode 4 (subtract) with at least two entries replaces the two top entries with the top entry minus the entry below it, modulo 2^W. Depth drops by one.
- R7: Opcode 6 (duplicate) on a stack that is neither empty nor full pushes a copy of the top entry.
- R8: Opcode 7 (swap) with at least two entries exchanges the top two entries and leaves depth unchanged.
- R9: Opcode 1 or opcode 6 on a full stack (depth = DEPTH) sets err_over. The stack contents and depth stay unchanged, and depth never exceeds DEPTH.
- R10: Opcode 2 on an empty stack, opcode 6 on an empty stack, and opcodes 3, 4, 5 or 7 with fewer than two entries all set err_under. The stack contents and depth stay unchanged.
- R11: Opcode 0 (no operation) changes neither the stack nor the flags.
- R12: The error flags are sticky until reset. An instruction_valid held high during the busy cycle is not taken as a second instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is offered |
| instr_op | input | 3 | Opcode (0 nop, 1 push, 2 pop, 3 add, 4 sub, 5 mul, 6 dup, 7 swap) |
| instr_data | input | W | Value used by push |
| ready | output | 1 | Core idle and able to accept |
| tos | output | W | Top entry, 0 when empty |
| depth | output | $clog2(DEPTH+1) | Number of occupied entries |
| empty | output | 1 | Depth is zero |
| full | output | 1 | Depth equals DEPTH |
| err_over | output | 1 | Sticky: a push or duplicate was refused |
| err_under | output | 1 | Sticky: an instruction lacked operands |
| pop_valid | output | 1 | One-cycle strobe for pop_data |
| pop_data | output | W | Word removed by the last pop |

## Verification
The bench drives the stack to both ends on purpose, using long runs biased toward pushes and then toward pops. This exercises refused pushes and duplicates at full depth, and refused pops, swaps and arithmetic with zero or one entry. A core whose full or empty test is off by one would either overwrite a wrapped slot or lose the last entry, and the shadow model's tos and depth would then disagree with it.

Subtract is checked with unequal operands, so a reversed operand order shows up as a negated result. Multiply is checked with an operand of all ones, which exposes a product that is not truncated to its low bits.

A directed case holds instr_valid high through the busy cycle. A core that re-accepted it would push a second value.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_ADD  = 3'd3,
        OP_SUB  = 3'd4,
        OP_MUL  = 3'd5,
        OP_DUP  = 3'd6,
        OP_SWAP = 3'd7
    } stk_op_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } stk_state_e;

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         instr_valid,
    input  logic [2:0]   instr_op,
    input  logic [W-1:0] instr_data,
    output logic         ready,
    output logic         exec_en,
    output stk_op_e      op_q,
    output logic [W-1:0] data_q
);

    stk_state_e state, state_nxt;
    logic       accept;

    assign accept = instr_valid && (state == ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions: accept (IDLE->EXEC), retire (EXEC->IDLE)
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (accept) state_nxt = ST_EXEC;
            ST_EXEC: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready   = 1'b0;
        exec_en = 1'b0;
        unique case (state)
            ST_IDLE: ready   = 1'b1;
            ST_EXEC: exec_en = 1'b1;
            default: ready   = 1'b0;
        endcase
    end

    // instruction latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_NOP;
            data_q <= '0;
        end else if (accept) begin
            op_q   <= stk_op_e'(instr_op);
            data_q <= instr_data;
        end
    end

endmodule

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
#(
    parameter int W = 32
) (
    input  stk_op_e      op,
    input  logic [W-1:0] top_val,
    input  logic [W-1:0] next_val,
    output logic [W-1:0] result
);

    localparam int PW = 2 * W;

    logic [PW-1:0] product;

    assign product = {{W{1'b0}}, top_val} * {{W{1'b0}}, next_val};

    always_comb begin
        unique case (op)
            OP_ADD:  result = top_val + next_val;
            OP_SUB:  result = top_val - next_val;
            OP_MUL:  result = product[W-1:0];
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/stk_store.sv
module stk_store
    import stk_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec_en,
    input  stk_op_e       op,
    input  logic [W-1:0]  push_val,
    input  logic [W-1:0]  alu_res,
    output logic [W-1:0]  top_val,
    output logic [W-1:0]  next_val,
    output logic [CW-1:0] count,
    output logic          err_over,
    output logic          err_under,
    output logic          pop_valid,
    output logic [W-1:0]  pop_data
);

    logic [W-1:0]  ent [DEPTH];
    logic [IW-1:0] top_idx, nxt_idx, free_idx;
    logic          has1, has2, is_full;

    logic          over_hit, under_hit, cnt_inc, cnt_dec, pop_fire;
    logic          free_we, nos_we, top_we;
    logic [W-1:0]  free_wv, nos_wv, top_wv;
    logic [DEPTH-1:0] ent_we;
    logic [W-1:0]  ent_wv [DEPTH];

    assign top_idx  = IW'(count - CW'(1));
    assign nxt_idx  = IW'(count - CW'(2));
    assign free_idx = IW'(count);
    assign has1     = (count != '0);
    assign has2     = (count >= CW'(2));
    assign is_full  = (count == CW'(DEPTH));

    assign top_val  = has1 ? ent[top_idx] : '0;
    assign next_val = has2 ? ent[nxt_idx] : '0;

    // decide the effect of the instruction being retired
    always_comb begin
        over_hit  = 1'b0;
        under_hit = 1'b0;
        cnt_inc   = 1'b0;
        cnt_dec   = 1'b0;
        pop_fire  = 1'b0;
        free_we   = 1'b0;
        nos_we    = 1'b0;
        top_we    = 1'b0;
        free_wv   = '0;
        nos_wv    = '0;
        top_wv    = '0;
        if (exec_en) begin
            unique case (op)
                OP_NOP: begin
                end
                OP_PUSH: begin
                    if (is_full) begin
                        over_hit = 1'b1;
                    end else begin
                        free_we = 1'b1;
                        free_wv = push_val;
                        cnt_inc = 1'b1;
                    end
                end
                OP_POP: begin
                    if (!has1) begin
                        under_hit = 1'b1;
                    end else begin
                        pop_fire = 1'b1;
                        cnt_dec  = 1'b1;
                    end
                end
                OP_ADD, OP_SUB, OP_MUL: begin
                    if (!has2) begin
                        under_hit = 1'b1;
                    end else begin
                        nos_we  = 1'b1;
                        nos_wv  = alu_res;
                        cnt_dec = 1'b1;
                    end
                end
                OP_DUP: begin
                    if (!has1) begin
                        under_hit = 1'b1;
                    end else if (is_full) begin
                        over_hit = 1'b1;
                    end else begin
                        free_we = 1'b1;
                        free_wv = top_val;
                        cnt_inc = 1'b1;
                    end
                end
                OP_SWAP: begin
                    if (!has2) begin
                        under_hit = 1'b1;
                    end else begin
                        top_we = 1'b1;
                        top_wv = next_val;
                        nos_we = 1'b1;
                        nos_wv = top_val;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // one register slot per entry
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_comb begin
            ent_we[g] = 1'b0;
            ent_wv[g] = '0;
            if (free_we && free_idx == IW'(g)) begin
                ent_we[g] = 1'b1;
                ent_wv[g] = free_wv;
            end else if (nos_we && nxt_idx == IW'(g)) begin
                ent_we[g] = 1'b1;
                ent_wv[g] = nos_wv;
            end else if (top_we && top_idx == IW'(g)) begin
                ent_we[g] = 1'b1;
                ent_wv[g] = top_wv;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent[g] <= '0;
            end else if (ent_we[g]) begin
                ent[g] <= ent_wv[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count     <= '0;
            err_over  <= 1'b0;
            err_under <= 1'b0;
            pop_valid <= 1'b0;
            pop_data  <= '0;
        end else begin
            if (cnt_inc) begin
                count <= count + CW'(1);
            end else if (cnt_dec) begin
                count <= count - CW'(1);
            end
            if (over_hit) err_over <= 1'b1;
            if (under_hit) err_under <= 1'b1;
            pop_valid <= pop_fire;
            if (pop_fire) pop_data <= top_val;
        end
    end

endmodule

// File: rtl/stk_core.sv
module stk_core
    import stk_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    input  logic [2:0]    instr_op,
    input  logic [W-1:0]  instr_data,
    output logic          ready,
    output logic [W-1:0]  tos,
    output logic [CW-1:0] depth,
    output logic          empty,
    output logic          full,
    output logic          err_over,
    output logic          err_under,
    output logic          pop_valid,
    output logic [W-1:0]  pop_data
);

    logic         exec_en;
    stk_op_e      op_q;
    logic [W-1:0] data_q;
    logic [W-1:0] top_val, next_val, alu_res;

    stk_ctrl #(.W(W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr_op    (instr_op),
        .instr_data  (instr_data),
        .ready       (ready),
        .exec_en     (exec_en),
        .op_q        (op_q),
        .data_q      (data_q)
    );

    stk_alu #(.W(W)) u_alu (
        .op       (op_q),
        .top_val  (top_val),
        .next_val (next_val),
        .result   (alu_res)
    );

    stk_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .exec_en   (exec_en),
        .op        (op_q),
        .push_val  (data_q),
        .alu_res   (alu_res),
        .top_val   (top_val),
        .next_val  (next_val),
        .count     (depth),
        .err_over  (err_over),
        .err_under (err_under),
        .pop_valid (pop_valid),
        .pop_data  (pop_data)
    );

    assign tos   = top_val;
    assign empty = (depth == '0);
    assign full  = (depth == CW'(DEPTH));

endmodule

// File: rtl/stk_core_chk.sv
module stk_core_chk #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          instr_valid,
    input logic          ready,
    input logic [CW-1:0] depth,
    input logic          err_over,
    input logic          err_under,
    input logic          pop_valid
);

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && ready) |=> !ready);

    p_busy_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ready);

    p_depth_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> $stable(depth));

    p_pop_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |=> !pop_valid);

    p_pop_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pop_valid) |-> (32'(depth) + 32'd1 == 32'($past(depth))));

    p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        32'(depth) <= DEPTH);

    p_over_keeps_depth_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_over) |-> $stable(depth));

    p_under_keeps_depth_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_under) |-> $stable(depth));

    p_over_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        err_over |=> err_over);

    p_under_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        err_under |=> err_under);

endmodule

bind stk_core stk_core_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .ready       (ready),
    .depth       (depth),
    .err_over    (err_over),
    .err_under   (err_under),
    .pop_valid   (pop_valid)
);

// File: tb/sim_stk_core.sv
`timescale 1ns/1ps
module sim_stk_core;

    localparam int W     = 32;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [2:0]    instr_op = 3'd0;
    logic [W-1:0]  instr_data = '0;
    logic          ready;
    logic [W-1:0]  tos;
    logic [CW-1:0] depth;
    logic          empty, full, err_over, err_under, pop_valid;
    logic [W-1:0]  pop_data;

    int total = 0;
    int bad   = 0;

    // shadow model
    logic [W-1:0] m_st [DEPTH];
    int           m_cnt;
    logic         m_over, m_under, m_popv;
    logic [W-1:0] m_popd;

    always #4 clk = ~clk;

    stk_core #(.W(W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
        .instr_data(instr_data), .ready(ready), .tos(tos), .depth(depth),
        .empty(empty), .full(full), .err_over(err_over), .err_under(err_under),
        .pop_valid(pop_valid), .pop_data(pop_data)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] m_tos();
        return (m_cnt > 0) ? m_st[m_cnt-1] : '0;
    endfunction

    // expected effect of one instruction; returns the requirement it exercises
    function automatic string model_step(input logic [2:0] op, input logic [W-1:0] d);
        logic [W-1:0] a, b;
        logic [2*W-1:0] p;
        string tag;
        m_popv = 1'b0;
        tag = "R11";
        case (op)
            3'd1: if (m_cnt == DEPTH) begin m_over = 1'b1; tag = "R9"; end
                  else begin m_st[m_cnt] = d; m_cnt++; tag = "R3"; end
            3'd2: if (m_cnt == 0) begin m_under = 1'b1; tag = "R10"; end
                  else begin m_popv = 1'b1; m_popd = m_st[m_cnt-1]; m_cnt--; tag = "R4"; end
            3'd3, 3'd4, 3'd5: if (m_cnt < 2) begin m_under = 1'b1; tag = "R10"; end
                  else begin
                      a = m_st[m_cnt-1];
                      b = m_st[m_cnt-2];
                      p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
                      if (op == 3'd3) begin m_st[m_cnt-2] = a + b; tag = "R5"; end
                      else if (op == 3'd4) begin m_st[m_cnt-2] = a - b; tag = "R6"; end
                      else begin m_st[m_cnt-2] = p[W-1:0]; tag = "R5"; end
                      m_cnt--;
                  end
            3'd6: if (m_cnt == 0) begin m_under = 1'b1; tag = "R10"; end
                  else if (m_cnt == DEPTH) begin m_over = 1'b1; tag = "R9"; end
                  else begin m_st[m_cnt] = m_st[m_cnt-1]; m_cnt++; tag = "R7"; end
            3'd7: if (m_cnt < 2) begin m_under = 1'b1; tag = "R10"; end
                  else begin
                      a = m_st[m_cnt-1];
                      m_st[m_cnt-1] = m_st[m_cnt-2];
                      m_st[m_cnt-2] = a;
                      tag = "R8";
                  end
            default: tag = "R11";
        endcase
        return tag;
    endfunction

    task automatic compare_all(input string tag);
        check(tag, "tos", tos, m_tos());
        check(tag, "depth", W'(depth), W'(m_cnt));
        check(tag, "err_over", W'(err_over), W'(m_over));
        check(tag, "err_under", W'(err_under), W'(m_under));
        check(tag, "pop_valid", W'(pop_valid), W'(m_popv));
        if (m_popv) check(tag, "pop_data", pop_data, m_popd);
        check("R2", "ready back", W'(ready), W'(1'b1));
    endtask

    // hold: keep instr_valid high through the busy cycle with other content
    task automatic issue(input logic [2:0] op, input logic [W-1:0] d, input bit hold);
        string tag;
        tag = model_step(op, d);
        @(negedge clk);
        while (!ready) @(negedge clk);
        instr_valid = 1'b1;
        instr_op    = op;
        instr_data  = d;
        @(negedge clk);
        check("R2", "busy", W'(ready), W'(1'b0));
        if (hold) begin
            instr_op   = 3'd1;
            instr_data = ~d;
        end else begin
            instr_valid = 1'b0;
        end
        @(negedge clk);
        instr_valid = 1'b0;
        compare_all(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_cnt = 0; m_over = 1'b0; m_under = 1'b0; m_popv = 1'b0; m_popd = '0;
        for (int i = 0; i < DEPTH; i++) m_st[i] = '0;
        @(negedge clk);
        check("R1", "ready", W'(ready), W'(1'b1));
        check("R1", "depth", W'(depth), '0);
        check("R1", "empty", W'(empty), W'(1'b1));
        check("R1", "full", W'(full), '0);
        check("R1", "tos", tos, '0);
        check("R1", "err_over", W'(err_over), '0);
        check("R1", "err_under", W'(err_under), '0);
        check("R1", "pop_valid", W'(pop_valid), '0);
    endtask

    initial begin
        int ncyc;
        ncyc = 0;
        forever begin
            @(posedge clk);
            ncyc++;
            if (ncyc > 150000) begin
                total++;
                bad++;
                $display("FAIL R2 watchdog: actual=hung expected=finished");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // directed corner cases
        issue(3'd2, '0, 0);                       // R10 pop on empty
        issue(3'd3, '0, 0);                       // R10 add with none
        do_reset();
        issue(3'd1, 32'd5, 0);                    // R3
        issue(3'd7, '0, 0);                       // R10 swap with one
        issue(3'd6, '0, 0);                       // R7
        issue(3'd2, '0, 0);                       // R4
        issue(3'd1, 32'd7, 0);
        issue(3'd1, 32'd9, 0);
        issue(3'd4, '0, 0);                       // R6: 9-7 = 2
        check("R6", "difference", tos, 32'd2);
        issue(3'd3, '0, 0);                       // R5: 2+5 = 7
        check("R5", "sum", tos, 32'd7);
        issue(3'd1, 32'hFFFF_FFFF, 0);
        issue(3'd1, 32'd3, 0);
        issue(3'd5, '0, 0);                       // R5: low bits
        check("R5", "product", tos, 32'hFFFF_FFFD);
        issue(3'd7, '0, 0);                       // R8
        check("R8", "swapped top", tos, 32'd7);
        issue(3'd0, '0, 0);                       // R11
        issue(3'd1, 32'hA5A5_0001, 1);            // R12 hold valid through busy
        check("R12", "single accept depth", W'(depth), W'(3));
        issue(3'd2, '0, 0);
        // fill to full, then overflow by push and by duplicate
        for (int i = 0; i < DEPTH; i++) issue(3'd1, W'(i * 3 + 1), 0);
        check("R9", "full flag", W'(full), W'(1'b1));
        issue(3'd6, '0, 0);                       // R9 dup on full
        issue(3'd1, 32'hDEAD_0000, 0);            // R9 push on full
        for (int i = 0; i < DEPTH + 2; i++) issue(3'd2, '0, 0);
        check("R12", "over still set", W'(err_over), W'(1'b1));
        check("R12", "under still set", W'(err_under), W'(1'b1));
        issue(3'd6, '0, 0);                       // R10 dup on empty

        // constrained random, alternating push-heavy and pop-heavy phases
        for (int blk = 0; blk < 12; blk++) begin
            if (blk % 4 == 0) do_reset();
            for (int n = 0; n < 200; n++) begin
                int r;
                logic [2:0] op;
                r = $urandom_range(0, 99);
                if (blk % 2 == 0) op = (r < 55) ? 3'd1 : 3'($urandom_range(0, 7));
                else              op = (r < 45) ? 3'd2 : 3'($urandom_range(0, 7));
                issue(op, $urandom(), ($urandom_range(0, 9) == 0));
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule